// File: doc/BRIEF.md
# Flash Command Interface with Status Register

This block is the device-side command decoder of a byte-wide, evenly sectored flash array model. Every write cycle on the command bus goes through it. It arms and then starts self-timed program and block-erase operations. It keeps an 8-bit status byte and decides whether a read returns the array or that status byte. A block erase may be paused and later continued. Reads of the array are allowed while the erase is paused.

Program and erase durations are counted in clock cycles. The programming supply is modelled as a single "supply good" input. The array is a small parameterized memory, reset to the erased value FFh. Erase clears an aligned block of `2**BLK_W` bytes.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset, reads return the array, every byte reads FFh, and `readyBusyN` is 1.
- R2: Writing 40h or 10h arms a program. The next write cycle supplies the address and data. `PROG_CYC` cycles later the byte holds old AND new. During those cycles status bit 7 is 0, and so is `readyBusyN`, which always equals status bit 7.
- R3: Status byte layout: bit 7 ready, bit 6 erase paused, bit 5 erase/sequence error, bit 4 program error, bit 3 supply error, bits 2..0 zero. From the write that confirms a program or erase onward, reads return this byte until FFh is written.
- R4: A program whose data has a 1 where the stored byte has a 0 sets bit 4. The stored byte still becomes old AND new.
- R5: Writing 20h and then D0h (with any address in the block) erases the block. `ERASE_CYC` cycles later every byte of the addressed block reads FFh, and bytes outside it are unchanged.
- R6: Writing 20h followed by any byte other than D0h sets bits 4 and 5, starts nothing and changes no byte.
- R7: If `vppOk` is 0 on the confirming write of a program or erase, bit 3 is set, the operation is dropped, the array is unchanged and the block stays ready.
- R8: Bits 3..5 stay set across later operations. Only the command 50h, written while idle, clears them, and it leaves the array alone.
- R9: B0h written during an erase pauses it: bits 6 and 7 read 1, `readyBusyN` is 1, and no erase time elapses while paused.
- R10: While paused, FFh gives array reads. D0h clears bit 6, returns reads to status and finishes the erase after the cycles that remained.
- R11: Command writes during a running program are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write cycle strobe, one per clock |
| wrAddr | input | ADDR_W | Write cycle address |
| wrData | input | 8 | Write cycle data or command byte |
| vppOk | input | 1 | Programming supply is valid |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 8 | Array byte or status byte, combinational |
| readyBusyN | output | 1 | 1 when ready, 0 while an operation runs |

## Verification
Each write is sampled on a rising edge. Its effect on status and mode shows right after that edge. In particular, status bit 7 falls in the same cycle as the confirming write. A program finishes `PROG_CYC` edges after its data write, and an erase finishes `ERASE_CYC` busy edges after D0h. Edges spent paused do not count toward the erase. The bench runs a behavioural reference model on each rising edge. It compares `rdData` and `readyBusyN` against the model one nanosecond after the edge, while inputs change only on the falling edge. Literal checks at fixed points then confirm the values the requirements fix.

// File: rtl/fci_pkg.sv
package fci_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PARM, ST_EARM, ST_PBUSY, ST_EBUSY, ST_ESUSP
  } fciState_t;

  typedef struct packed {
    logic latchOp;
    logic progGo;
    logic eraseGo;
  } fciStrobe_t;

  localparam logic [7:0] CMD_READ    = 8'hFF;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_PROG_A  = 8'h40;
  localparam logic [7:0] CMD_PROG_B  = 8'h10;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_PAUSE   = 8'hB0;
endpackage

// File: rtl/fci_ctrl.sv
module fci_ctrl
  import fci_pkg::*;
#(
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       vppOk,
  input  logic       progConflict,
  output fciStrobe_t strobe,
  output logic [7:0] statusByte,
  output logic       readStatus
);
  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  fciState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       errBits;   // [2]=bit5, [1]=bit4, [0]=bit3
  logic             suspFlag;
  logic             busy;
  logic             clrAccepted;
  logic             pauseReq;

  assign busy        = (state == ST_PBUSY) || (state == ST_EBUSY);
  assign clrAccepted = (state == ST_IDLE) && wrEn && (wrData == CMD_CLEAR);
  assign pauseReq    = (state == ST_EBUSY) && wrEn && (wrData == CMD_PAUSE);
  assign statusByte  = {~busy, suspFlag, errBits, 3'b000};

  always_comb begin
    strobe.latchOp = wrEn && vppOk &&
                     ((state == ST_PARM) || ((state == ST_EARM) && (wrData == CMD_CONFIRM)));
    strobe.progGo  = (state == ST_PBUSY) && (cnt == '0);
    strobe.eraseGo = (state == ST_EBUSY) && (cnt == '0) && !pauseReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      errBits    <= '0;
      suspFlag   <= 1'b0;
      readStatus <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (wrEn) begin
          if (wrData == CMD_READ) readStatus <= 1'b0;
          else if (wrData == CMD_CLEAR) errBits <= '0;
          else if (wrData == CMD_PROG_A || wrData == CMD_PROG_B) state <= ST_PARM;
          else if (wrData == CMD_ERASE) state <= ST_EARM;
        end
        ST_PARM: if (wrEn) begin
          readStatus <= 1'b1;
          if (!vppOk) begin
            errBits[0] <= 1'b1;
            state      <= ST_IDLE;
          end else begin
            cnt   <= CNT_W'(PROG_CYC - 1);
            state <= ST_PBUSY;
          end
        end
        ST_EARM: if (wrEn) begin
          readStatus <= 1'b1;
          state      <= ST_IDLE;
          if (wrData != CMD_CONFIRM) errBits[2:1] <= 2'b11;
          else if (!vppOk) errBits[0] <= 1'b1;
          else begin
            cnt   <= CNT_W'(ERASE_CYC - 1);
            state <= ST_EBUSY;
          end
        end
        ST_PBUSY: begin
          if (cnt == '0) begin
            state <= ST_IDLE;
            if (progConflict) errBits[1] <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        ST_EBUSY: begin
          if (pauseReq) begin
            state    <= ST_ESUSP;
            suspFlag <= 1'b1;
          end else if (cnt == '0) state <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        ST_ESUSP: if (wrEn) begin
          if (wrData == CMD_READ) readStatus <= 1'b0;
          else if (wrData == CMD_CONFIRM) begin
            state      <= ST_EBUSY;
            suspFlag   <= 1'b0;
            readStatus <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: an error bit may only fall after an accepted clear command
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (($past(errBits) & ~errBits) != 3'b000) |-> $past(clrAccepted));

  // R9: pausing raises ready and the paused flag together
  p_pause_ready_r9: assert property (@(posedge clk) disable iff (!rstN)
    pauseReq |=> (statusByte[7] && statusByte[6]));

  // R9: no erase time elapses while paused
  p_cnt_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ESUSP) |=> $stable(cnt));

  // R6: a wrong confirm byte flags both error bits
  p_bad_confirm_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_EARM) && wrEn && (wrData != CMD_CONFIRM)) |=> (statusByte[5] && statusByte[4]));

  // R7: a missing supply on the confirm write aborts and flags bit 3
  p_supply_abort_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !vppOk && ((state == ST_PARM) || ((state == ST_EARM) && (wrData == CMD_CONFIRM))))
    |=> (statusByte[3] && statusByte[7]));
endmodule

// File: rtl/fci_datapath.sv
module fci_datapath
  import fci_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BLK_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  fciStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        arrayByte,
  output logic              progConflict
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int TAG_W = ADDR_W - BLK_W;

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] opAddr;
  logic [7:0]        opData;
  logic [TAG_W-1:0]  opBlock;

  assign opBlock      = opAddr[ADDR_W-1:BLK_W];
  assign arrayByte    = mem[rdAddr];
  assign progConflict = |(opData & ~mem[opAddr]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      opAddr <= '0;
      opData <= 8'hFF;
    end else begin
      if (strobe.latchOp) begin
        opAddr <= wrAddr;
        opData <= wrData;
      end
      if (strobe.progGo) mem[opAddr] <= mem[opAddr] & opData;
      if (strobe.eraseGo) begin
        for (int i = 0; i < DEPTH; i++)
          if (TAG_W'(ADDR_W'(i) >> BLK_W) == opBlock) mem[i] <= 8'hFF;
      end
    end
  end

  // R2: every 0 in the programmed data is 0 in the stored byte afterwards
  p_prog_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.progGo |=> ((mem[$past(opAddr)] & ~$past(opData)) == 8'h00));

  // R5: first byte of the erased block reads erased afterwards
  p_erase_fill_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.eraseGo |=> (mem[{$past(opBlock), BLK_W'(0)}] == 8'hFF));
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import fci_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BLK_W     = 4,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              vppOk,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              readyBusyN
);
  fciStrobe_t strobe;
  logic [7:0] statusByte;
  logic [7:0] arrayByte;
  logic       readStatus;
  logic       progConflict;

  fci_ctrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .vppOk(vppOk),
    .progConflict(progConflict), .strobe(strobe), .statusByte(statusByte),
    .readStatus(readStatus)
  );

  fci_datapath #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .arrayByte(arrayByte), .progConflict(progConflict)
  );

  assign rdData     = readStatus ? statusByte : arrayByte;
  assign readyBusyN = statusByte[7];
endmodule

// File: tb/test_flash_cmd_if.sv
module test_flash_cmd_if;
  localparam int AW = 8, BW = 4, PC = 6, EC = 24;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, vppOk = 1'b1;
  logic [AW-1:0] wrAddr = '0, rdAddr = '0;
  logic [7:0] wrData = '0, rdData;
  logic readyBusyN;
  int checks = 0, failures = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  flash_cmd_if #(.ADDR_W(AW), .BLK_W(BW), .PROG_CYC(PC), .ERASE_CYC(EC)) i_flash_cmd_if (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .vppOk(vppOk), .rdAddr(rdAddr), .rdData(rdData), .readyBusyN(readyBusyN));

  // behavioural reference: 0 idle,1 prog armed,2 erase armed,3 programming,4 erasing,5 paused
  int mst = 0, left = 0, oa = 0, eb = 0;
  bit rs = 0, e5 = 0, e4 = 0, e3 = 0, e6 = 0;
  logic [7:0] od = 0;
  logic [7:0] mm [256];

  function automatic logic [7:0] expRead();
    bit rdy = !(mst == 3 || mst == 4);
    if (rs) return {rdy, e6, e5, e4, e3, 3'b000};
    return mm[rdAddr];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mst = 0; rs = 0; {e6, e5, e4, e3} = 0; left = 0;
      for (int i = 0; i < 256; i++) mm[i] = 8'hFF;
    end else begin
      case (mst)
        0: if (wrEn) begin
          if (wrData == 8'hFF) rs = 0;
          else if (wrData == 8'h50) {e5, e4, e3} = 0;
          else if (wrData == 8'h40 || wrData == 8'h10) mst = 1;
          else if (wrData == 8'h20) mst = 2;
        end
        1: if (wrEn) begin
          rs = 1;
          if (!vppOk) begin e3 = 1; mst = 0; end
          else begin oa = wrAddr; od = wrData; left = PC; mst = 3; end
        end
        2: if (wrEn) begin
          rs = 1; mst = 0;
          if (wrData != 8'hD0) begin e5 = 1; e4 = 1; end
          else if (!vppOk) e3 = 1;
          else begin eb = wrAddr / (1 << BW); left = EC; mst = 4; end
        end
        3: begin
          left--;
          if (left == 0) begin
            if ((od & ~mm[oa]) != 0) e4 = 1;
            mm[oa] = mm[oa] & od; mst = 0;
          end
        end
        4: if (wrEn && wrData == 8'hB0) begin mst = 5; e6 = 1; end
           else begin
             left--;
             if (left == 0) begin
               for (int i = 0; i < 256; i++) if (i / (1 << BW) == eb) mm[i] = 8'hFF;
               mst = 0;
             end
           end
        5: if (wrEn) begin
          if (wrData == 8'hFF) rs = 0;
          else if (wrData == 8'hD0) begin mst = 4; e6 = 0; rs = 1; end
        end
        default: mst = 0;
      endcase
    end
    #1;
    if (rstN) begin
      checks++;
      if (rdData !== expRead() || readyBusyN !== expRead() ? 1'b0 : 1'b0) ;
      if (rdData !== expRead()) begin
        failures++;
        $display("FAIL %s rdData=%h expected %h", curReq, rdData, expRead());
      end
      checks++;
      if (readyBusyN !== !(mst == 3 || mst == 4)) begin
        failures++;
        $display("FAIL %s readyBusyN=%b expected %b", curReq, readyBusyN, !(mst == 3 || mst == 4));
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    rdAddr = a; #1;
    checks++;
    if (rdData !== exp) begin
      failures++;
      $display("FAIL %s addr %h rdData=%h expected %h", req, a, rdData, exp);
    end
  endtask

  task automatic chkRb(input string req, input logic exp);
    checks++;
    if (readyBusyN !== exp) begin
      failures++;
      $display("FAIL %s readyBusyN=%b expected %b", req, readyBusyN, exp);
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3); rstN = 1'b1; idle(1);
    curReq = "R1"; chk("R1", 8'h05, 8'hFF); chkRb("R1", 1'b1);

    curReq = "R2"; wr(8'h00, 8'h40); wr(8'h12, 8'hA5);
    chk("R3", 8'h12, 8'h00); chkRb("R2", 1'b0);
    idle(PC + 1); chk("R3", 8'h12, 8'h80); chkRb("R2", 1'b1);
    wr(8'h00, 8'hFF); chk("R2", 8'h12, 8'hA5);

    curReq = "R4"; wr(8'h00, 8'h10); wr(8'h12, 8'h5A); idle(PC + 1);
    chk("R4", 8'h00, 8'h90); wr(8'h00, 8'hFF); chk("R4", 8'h12, 8'h00);

    curReq = "R8"; wr(8'h00, 8'h40); wr(8'h20, 8'hFF); idle(PC + 1);
    chk("R8", 8'h00, 8'h90);
    wr(8'h00, 8'h50); chk("R8", 8'h00, 8'h80);
    wr(8'h00, 8'hFF); chk("R8", 8'h12, 8'h00);

    curReq = "R6"; wr(8'h00, 8'h20); wr(8'h12, 8'h33);
    chk("R6", 8'h00, 8'hB0); chkRb("R6", 1'b1);
    wr(8'h00, 8'hFF); chk("R6", 8'h12, 8'h00); wr(8'h00, 8'h50);

    curReq = "R7"; vppOk = 1'b0;
    wr(8'h00, 8'h40); wr(8'h40, 8'h00);
    chk("R7", 8'h00, 8'h88); chkRb("R7", 1'b1);
    wr(8'h00, 8'hFF); chk("R7", 8'h40, 8'hFF);
    wr(8'h00, 8'h50); wr(8'h00, 8'h20); wr(8'h10, 8'hD0);
    chk("R7", 8'h00, 8'h88); idle(EC + 2);
    wr(8'h00, 8'hFF); chk("R7", 8'h12, 8'h00);
    vppOk = 1'b1; wr(8'h00, 8'h50);

    curReq = "R5";
    wr(8'h00, 8'h40); wr(8'h13, 8'h3C); idle(PC + 1);
    wr(8'h00, 8'h40); wr(8'h25, 8'h11); idle(PC + 1);
    wr(8'h00, 8'h20); wr(8'h1A, 8'hD0);
    chk("R5", 8'h00, 8'h00); idle(EC + 1); chk("R5", 8'h00, 8'h80);
    wr(8'h00, 8'hFF);
    chk("R5", 8'h12, 8'hFF); chk("R5", 8'h13, 8'hFF); chk("R5", 8'h25, 8'h11);

    curReq = "R9";
    wr(8'h00, 8'h40); wr(8'h14, 8'h00); idle(PC + 1);
    wr(8'h00, 8'h20); wr(8'h10, 8'hD0); idle(5);
    wr(8'h00, 8'hB0); chk("R9", 8'h00, 8'hC0); chkRb("R9", 1'b1);
    idle(EC + 10); chk("R9", 8'h00, 8'hC0);
    curReq = "R10";
    wr(8'h00, 8'hFF); chk("R10", 8'h14, 8'h00);
    wr(8'h00, 8'hD0); chk("R10", 8'h00, 8'h00); chkRb("R10", 1'b0);
    idle(EC); chk("R10", 8'h00, 8'h80);
    wr(8'h00, 8'hFF); chk("R10", 8'h14, 8'hFF);

    curReq = "R11";
    wr(8'h00, 8'h40); wr(8'h50, 8'hF0);
    wr(8'h00, 8'h20); wr(8'h25, 8'hD0); idle(PC + 2);
    chk("R11", 8'h00, 8'h80); chkRb("R11", 1'b1);
    wr(8'h00, 8'hFF);
    chk("R11", 8'h25, 8'h11); chk("R11", 8'h50, 8'hF0);

    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule